// File: doc/BRIEF.md
# Interrupt-Return Segment Validation Unit

This unit decides, before a return-from-interrupt changes any architectural state, whether the popped return context is legal. A request carries the current privilege level, the operating mode (real or protected), a locked-prefix flag, the popped instruction pointer, the stack pointer, the code and stack selectors with their already-decoded descriptors, and the descriptor-table byte limit. Descriptor fetch, paging, task switching, alignment and flag restoration happen elsewhere.

The unit captures the request in one cycle and evaluates it in the next. It then presents one verdict, either success or a single fault with its class and a 16-bit error code, and holds that verdict until the requester acknowledges it. When more than one rule is broken, only the highest-priority failure is reported.

Top module: `iret_guard`

## Requirements
- R1: A request with `req_lock` set yields fault class UD (code 4) with error code 0 in either mode, whatever else is wrong.
- R2: Selector layout is index in bits 15:3, table indicator in bit 2, RPL in bits 1:0. A selector is null when bits 15:2 are all zero. In protected mode a null code or stack selector yields GP (code 1) with error code 0.
- R3: In protected mode, a selector whose last descriptor byte (`{sel[15:3],3'b111}`) exceeds `req_tbl_limit` yields GP with that selector as the error code.
- R4: In protected mode, a code descriptor that is not a code type, or a code selector RPL numerically above the current privilege level, yields GP with the code selector as the error code.
- R5: In protected mode, a conforming code segment with DPL above the code selector RPL, or a non-conforming one with DPL different from that RPL, yields GP with the code selector. A conforming segment with DPL at or below the RPL passes.
- R6: In protected mode, a stack selector RPL different from the code selector RPL, a stack descriptor that is not a writable data segment, or a stack DPL different from the code selector RPL yields GP with the stack selector as the error code.
- R7: In protected mode, a code or stack descriptor marked not present yields NP (code 3) with that selector as the error code.
- R8: In both modes, a return instruction pointer above `req_cs_limit` yields GP with error code 0.
- R9: In both modes, when `req_esp + POP_BYTES - 1` (default 12 bytes) exceeds `req_ss_limit`, the result is SS (code 2) with error code 0. In real mode only R1, R8 and R9 apply, and selector and descriptor fields have no effect.
- R10: Priority, first failure wins: locked prefix; code selector null, table range, type, RPL against privilege level, DPL; code present; instruction pointer limit; stack selector null, table range, RPL, type, DPL, present; stack limit.
- R11: `req_ready` is high only while idle. The verdict appears with `rsp_valid` two cycles after acceptance. `rsp_ok` is high exactly when the class is 0 (no fault). Class and error code hold steady with `rsp_valid` until a cycle with `rsp_ack`, after which the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_protected | input | 1 | 1 = protected mode, 0 = real mode |
| req_lock | input | 1 | Locked prefix present |
| req_cpl | input | 2 | Current privilege level |
| req_eip | input | ADDR_W | Popped return instruction pointer |
| req_esp | input | ADDR_W | Stack pointer to the bytes being popped |
| req_tbl_limit | input | 16 | Descriptor-table byte limit |
| req_cs_sel | input | 16 | Code selector |
| req_cs_is_code | input | 1 | Code descriptor is a code type |
| req_cs_conforming | input | 1 | Code descriptor is conforming |
| req_cs_dpl | input | 2 | Code descriptor DPL |
| req_cs_present | input | 1 | Code descriptor present |
| req_cs_limit | input | ADDR_W | Code segment limit |
| req_ss_sel | input | 16 | Stack selector |
| req_ss_is_code | input | 1 | Stack descriptor is a code type |
| req_ss_writable | input | 1 | Stack descriptor writable |
| req_ss_dpl | input | 2 | Stack descriptor DPL |
| req_ss_present | input | 1 | Stack descriptor present |
| req_ss_limit | input | ADDR_W | Stack segment limit |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ack | input | 1 | Requester consumes verdict |
| rsp_ok | output | 1 | No fault |
| rsp_fault | output | 3 | 0 none, 1 GP, 2 SS, 3 NP, 4 UD |
| rsp_err | output | 16 | Error code |

## Verification
The bench targets overlapping failures. A priority chain in the wrong order would report, for example, the instruction-pointer fault in place of the not-present code segment, or a stack fault in place of the locked prefix. Limit and table checks are exercised exactly at the last legal byte and one past it, so an off-by-one compare would fault a legal request or pass an illegal one. A conforming segment with a lower DPL must pass where a non-conforming one faults; this catches a swapped comparison. Real-mode requests with garbage selectors must pass, and a verdict left unacknowledged must not drift or drop, or the requester would read a wrong or vanished fault.

// File: rtl/iret_guard_pkg.sv
// Shared types for the interrupt-return validation unit.
// Assumes 16-bit selectors with RPL in bits 1:0 and index in 15:3.
package iret_guard_pkg;

    localparam int SEL_W = 16;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_GP   = 3'd1,
        FLT_SS   = 3'd2,
        FLT_NP   = 3'd3,
        FLT_UD   = 3'd4
    } fault_e;

    typedef struct packed {
        logic       is_code;
        logic       writable;
        logic       conforming;
        logic [1:0] dpl;
        logic       present;
    } desc_attr_t;

endpackage

// File: rtl/iret_sel_check.sv
// Per-selector decode: null detect, table-range detect and RPL extraction.
// Assumes the table limit is a byte limit and descriptors are 8 bytes.
module iret_sel_check #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [SEL_W-1:0] tbl_limit,
    output logic             is_null,
    output logic             past_tbl,
    output logic [1:0]       rpl
);

    logic [SEL_W-1:0] last_byte;

    // Decode the selector fields that the rule chain consumes.
    always_comb begin
        last_byte = {sel[SEL_W-1:3], 3'b111};
        is_null   = (sel[SEL_W-1:2] == '0);
        past_tbl  = (last_byte > tbl_limit);
        rpl       = sel[1:0];
    end

endmodule

// File: rtl/iret_rule_eval.sv
// Combinational rule chain: returns the first failing check in priority order.
// Assumes descriptor attributes are already decoded by the requester.
module iret_rule_eval
    import iret_guard_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int POP_BYTES = 12
) (
    input  logic              prot,
    input  logic              lock,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] eip,
    input  logic [ADDR_W-1:0] esp,
    input  logic [SEL_W-1:0]  tbl_limit,
    input  logic [SEL_W-1:0]  cs_sel,
    input  desc_attr_t        cs_attr,
    input  logic [ADDR_W-1:0] cs_limit,
    input  logic [SEL_W-1:0]  ss_sel,
    input  desc_attr_t        ss_attr,
    input  logic [ADDR_W-1:0] ss_limit,
    output fault_e            fault,
    output logic [SEL_W-1:0]  err
);

    localparam int NSEL = 2;
    localparam logic [ADDR_W:0] POP_SPAN = (ADDR_W+1)'(POP_BYTES - 1);

    logic [SEL_W-1:0] sel_arr  [NSEL];
    logic             null_arr [NSEL];
    logic             past_arr [NSEL];
    logic [1:0]       rpl_arr  [NSEL];

    assign sel_arr[0] = cs_sel;
    assign sel_arr[1] = ss_sel;

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
        iret_sel_check #(.SEL_W(SEL_W)) sel_i (
            .sel      (sel_arr[gi]),
            .tbl_limit(tbl_limit),
            .is_null  (null_arr[gi]),
            .past_tbl (past_arr[gi]),
            .rpl      (rpl_arr[gi])
        );
    end

    logic [ADDR_W:0] stack_top;
    logic            eip_bad;
    logic            stk_bad;
    logic            cs_dpl_bad;
    logic            ss_type_bad;

    // Derive the compare results shared by both modes.
    always_comb begin
        stack_top   = {1'b0, esp} + POP_SPAN;
        eip_bad     = (eip > cs_limit);
        stk_bad     = (stack_top > {1'b0, ss_limit});
        cs_dpl_bad  = cs_attr.conforming ? (cs_attr.dpl > rpl_arr[0])
                                         : (cs_attr.dpl != rpl_arr[0]);
        ss_type_bad = ss_attr.is_code || !ss_attr.writable;
    end

    // Walk the priority chain; the first hit sets class and error code.
    always_comb begin
        fault = FLT_NONE;
        err   = '0;
        if (lock) begin
            fault = FLT_UD;
        end else if (!prot) begin
            if (eip_bad)      fault = FLT_GP;
            else if (stk_bad) fault = FLT_SS;
        end else if (null_arr[0]) begin
            fault = FLT_GP;
        end else if (past_arr[0] || !cs_attr.is_code || (rpl_arr[0] > cpl) || cs_dpl_bad) begin
            fault = FLT_GP;
            err   = cs_sel;
        end else if (!cs_attr.present) begin
            fault = FLT_NP;
            err   = cs_sel;
        end else if (eip_bad) begin
            fault = FLT_GP;
        end else if (null_arr[1]) begin
            fault = FLT_GP;
        end else if (past_arr[1] || (rpl_arr[1] != rpl_arr[0]) || ss_type_bad
                     || (ss_attr.dpl != rpl_arr[0])) begin
            fault = FLT_GP;
            err   = ss_sel;
        end else if (!ss_attr.present) begin
            fault = FLT_NP;
            err   = ss_sel;
        end else if (stk_bad) begin
            fault = FLT_SS;
        end
    end

endmodule

// File: rtl/iret_guard.sv
// Interrupt-return validation unit: capture, evaluate, hold verdict until ack.
// Assumes one request in flight; inputs are sampled only on acceptance.
module iret_guard
    import iret_guard_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int POP_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_protected,
    input  logic              req_lock,
    input  logic [1:0]        req_cpl,
    input  logic [ADDR_W-1:0] req_eip,
    input  logic [ADDR_W-1:0] req_esp,
    input  logic [15:0]       req_tbl_limit,
    input  logic [15:0]       req_cs_sel,
    input  logic              req_cs_is_code,
    input  logic              req_cs_conforming,
    input  logic [1:0]        req_cs_dpl,
    input  logic              req_cs_present,
    input  logic [ADDR_W-1:0] req_cs_limit,
    input  logic [15:0]       req_ss_sel,
    input  logic              req_ss_is_code,
    input  logic              req_ss_writable,
    input  logic [1:0]        req_ss_dpl,
    input  logic              req_ss_present,
    input  logic [ADDR_W-1:0] req_ss_limit,
    output logic              rsp_valid,
    input  logic              rsp_ack,
    output logic              rsp_ok,
    output logic [2:0]        rsp_fault,
    output logic [15:0]       rsp_err
);

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_RESP} state_e;

    state_e            state_q;
    logic              prot_q, lock_q;
    logic [1:0]        cpl_q;
    logic [ADDR_W-1:0] eip_q, esp_q, cs_lim_q, ss_lim_q;
    logic [SEL_W-1:0]  tbl_q, cs_sel_q, ss_sel_q;
    desc_attr_t        cs_attr_q, ss_attr_q;
    fault_e            eval_fault;
    logic [SEL_W-1:0]  eval_err;
    fault_e            fault_q;
    logic [SEL_W-1:0]  err_q;
    logic              ok_q;

    logic accept;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            prot_q    <= req_protected;
            lock_q    <= req_lock;
            cpl_q     <= req_cpl;
            eip_q     <= req_eip;
            esp_q     <= req_esp;
            tbl_q     <= req_tbl_limit;
            cs_sel_q  <= req_cs_sel;
            ss_sel_q  <= req_ss_sel;
            cs_lim_q  <= req_cs_limit;
            ss_lim_q  <= req_ss_limit;
            cs_attr_q <= '{is_code: req_cs_is_code, writable: 1'b0,
                           conforming: req_cs_conforming, dpl: req_cs_dpl,
                           present: req_cs_present};
            ss_attr_q <= '{is_code: req_ss_is_code, writable: req_ss_writable,
                           conforming: 1'b0, dpl: req_ss_dpl,
                           present: req_ss_present};
        end
    end

    iret_rule_eval #(.ADDR_W(ADDR_W), .POP_BYTES(POP_BYTES)) eval_i (
        .prot     (prot_q),
        .lock     (lock_q),
        .cpl      (cpl_q),
        .eip      (eip_q),
        .esp      (esp_q),
        .tbl_limit(tbl_q),
        .cs_sel   (cs_sel_q),
        .cs_attr  (cs_attr_q),
        .cs_limit (cs_lim_q),
        .ss_sel   (ss_sel_q),
        .ss_attr  (ss_attr_q),
        .ss_limit (ss_lim_q),
        .fault    (eval_fault),
        .err      (eval_err)
    );

    // Sequence idle -> evaluate -> respond, holding the verdict until ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= FLT_NONE;
            err_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_EVAL;
                ST_EVAL: begin
                    fault_q <= eval_fault;
                    err_q   <= eval_err;
                    ok_q    <= (eval_fault == FLT_NONE);
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_ok    = ok_q;
    assign rsp_fault = fault_q;
    assign rsp_err   = err_q;

    // Verdict stays put while the requester has not acknowledged it.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_err) && $stable(rsp_ok));

    // Acceptance leads to one evaluation cycle, then the verdict.
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !rsp_valid ##1 rsp_valid);

    // Never ready while a verdict is pending.
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // A locked request always ends as an invalid-opcode verdict with code 0.
    p_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) && lock_q |=> rsp_fault == 3'(FLT_UD) && rsp_err == '0);

    // Real-mode verdicts never carry a selector nor a not-present class.
    p_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) && !prot_q |=> rsp_err == '0 && rsp_fault != 3'(FLT_NP));

    // Stack-limit verdicts carry a zero error code.
    p_ss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'(FLT_SS) |-> rsp_err == '0);

    // Success flag and no-fault class agree.
    p_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_ok == (rsp_fault == 3'(FLT_NONE)));

endmodule

// File: tb/iret_guard_tb_top.sv
`timescale 1ns/1ps
module iret_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_protected, req_lock;
    logic [1:0]  req_cpl;
    logic [31:0] req_eip, req_esp;
    logic [15:0] req_tbl_limit, req_cs_sel, req_ss_sel;
    logic        req_cs_is_code, req_cs_conforming, req_cs_present;
    logic [1:0]  req_cs_dpl, req_ss_dpl;
    logic [31:0] req_cs_limit, req_ss_limit;
    logic        req_ss_is_code, req_ss_writable, req_ss_present;
    logic        rsp_valid, rsp_ok;
    logic        rsp_ack = 1'b0;
    logic [2:0]  rsp_fault;
    logic [15:0] rsp_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iret_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_protected(req_protected), .req_lock(req_lock), .req_cpl(req_cpl),
        .req_eip(req_eip), .req_esp(req_esp), .req_tbl_limit(req_tbl_limit),
        .req_cs_sel(req_cs_sel), .req_cs_is_code(req_cs_is_code),
        .req_cs_conforming(req_cs_conforming), .req_cs_dpl(req_cs_dpl),
        .req_cs_present(req_cs_present), .req_cs_limit(req_cs_limit),
        .req_ss_sel(req_ss_sel), .req_ss_is_code(req_ss_is_code),
        .req_ss_writable(req_ss_writable), .req_ss_dpl(req_ss_dpl),
        .req_ss_present(req_ss_present), .req_ss_limit(req_ss_limit),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_ok(rsp_ok),
        .rsp_fault(rsp_fault), .rsp_err(rsp_err)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  op;
        logic [31:0] prm;
        logic [2:0]  fault;
        logic [15:0] err;
    } vec_t;

    localparam int NV = 34;
    // Classes: 0 none, 1 GP, 2 SS, 3 NP, 4 UD.
    localparam vec_t VECS [NV] = '{
        '{8'd11, 8'd0,  32'h0,     3'd0, 16'h0000}, // R11 clean request
        '{8'd1,  8'd1,  32'h0,     3'd4, 16'h0000}, // R1 lock
        '{8'd2,  8'd2,  32'h0,     3'd1, 16'h0000}, // R2 null code selector
        '{8'd2,  8'd3,  32'h0,     3'd1, 16'h0000}, // R2 null stack selector
        '{8'd3,  8'd4,  32'h00FB,  3'd0, 16'h0000}, // R3 code index at table end
        '{8'd3,  8'd4,  32'h0103,  3'd1, 16'h0103}, // R3 code index past table
        '{8'd3,  8'd5,  32'h00FB,  3'd0, 16'h0000}, // R3 stack index at table end
        '{8'd3,  8'd5,  32'h0203,  3'd1, 16'h0203}, // R3 stack index past table
        '{8'd4,  8'd6,  32'h0,     3'd1, 16'h001B}, // R4 code type wrong
        '{8'd4,  8'd7,  32'h2,     3'd1, 16'h001B}, // R4 RPL above CPL
        '{8'd5,  8'd8,  32'h0,     3'd1, 16'h001B}, // R5 non-conforming DPL mismatch
        '{8'd5,  8'd9,  32'h0,     3'd0, 16'h0000}, // R5 conforming lower DPL ok
        '{8'd5,  8'd10, 32'h0,     3'd1, 16'h001A}, // R5 conforming DPL above RPL
        '{8'd6,  8'd11, 32'h0,     3'd1, 16'h0022}, // R6 stack RPL differs
        '{8'd6,  8'd12, 32'h0,     3'd1, 16'h0023}, // R6 stack is code
        '{8'd6,  8'd13, 32'h0,     3'd1, 16'h0023}, // R6 stack read-only
        '{8'd6,  8'd14, 32'h0,     3'd1, 16'h0023}, // R6 stack DPL differs
        '{8'd7,  8'd15, 32'h0,     3'd3, 16'h001B}, // R7 code absent
        '{8'd7,  8'd16, 32'h0,     3'd3, 16'h0023}, // R7 stack absent
        '{8'd8,  8'd17, 32'hFFFF,  3'd0, 16'h0000}, // R8 eip at limit
        '{8'd8,  8'd17, 32'h10000, 3'd1, 16'h0000}, // R8 eip past limit
        '{8'd9,  8'd18, 32'hFFF4,  3'd0, 16'h0000}, // R9 stack top at limit
        '{8'd9,  8'd18, 32'hFFF5,  3'd2, 16'h0000}, // R9 stack top past limit
        '{8'd8,  8'd19, 32'h0,     3'd1, 16'h0000}, // R8 real mode eip
        '{8'd9,  8'd20, 32'h0,     3'd0, 16'h0000}, // R9 real mode ignores selectors
        '{8'd9,  8'd21, 32'h0,     3'd2, 16'h0000}, // R9 real mode stack
        '{8'd1,  8'd22, 32'h0,     3'd4, 16'h0000}, // R1 real mode lock
        '{8'd10, 8'd23, 32'h0,     3'd4, 16'h0000}, // R10 lock over null code
        '{8'd10, 8'd24, 32'h0,     3'd3, 16'h001B}, // R10 code absent over eip
        '{8'd10, 8'd25, 32'h0,     3'd1, 16'h0000}, // R10 eip over stack absent
        '{8'd10, 8'd26, 32'h0,     3'd1, 16'h001B}, // R10 code type over code absent
        '{8'd10, 8'd27, 32'h0,     3'd3, 16'h0023}, // R10 stack absent over stack limit
        '{8'd10, 8'd28, 32'h0,     3'd1, 16'h0022}, // R10 stack RPL over stack type
        '{8'd10, 8'd29, 32'h0,     3'd1, 16'h0000}  // R10 lock-free null code over stack faults
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_base();
        req_protected = 1'b1; req_lock = 1'b0; req_cpl = 2'd3;
        req_eip = 32'h1000; req_esp = 32'h8000; req_tbl_limit = 16'h00FF;
        req_cs_sel = 16'h001B; req_cs_is_code = 1'b1; req_cs_conforming = 1'b0;
        req_cs_dpl = 2'd3; req_cs_present = 1'b1; req_cs_limit = 32'hFFFF;
        req_ss_sel = 16'h0023; req_ss_is_code = 1'b0; req_ss_writable = 1'b1;
        req_ss_dpl = 2'd3; req_ss_present = 1'b1; req_ss_limit = 32'hFFFF;
    endtask

    task automatic apply(input logic [7:0] op, input logic [31:0] prm);
        case (op)
            8'd1:  req_lock = 1'b1;
            8'd2:  req_cs_sel = 16'h0003;
            8'd3:  req_ss_sel = 16'h0003;
            8'd4:  req_cs_sel = prm[15:0];
            8'd5:  req_ss_sel = prm[15:0];
            8'd6:  req_cs_is_code = 1'b0;
            8'd7:  req_cpl = prm[1:0];
            8'd8:  req_cs_dpl = 2'd2;
            8'd9:  begin req_cs_conforming = 1'b1; req_cs_dpl = 2'd2; end
            8'd10: begin req_cs_sel = 16'h001A; req_ss_sel = 16'h0022; req_ss_dpl = 2'd2;
                         req_cs_conforming = 1'b1; req_cs_dpl = 2'd3; end
            8'd11: req_ss_sel = 16'h0022;
            8'd12: req_ss_is_code = 1'b1;
            8'd13: req_ss_writable = 1'b0;
            8'd14: req_ss_dpl = 2'd2;
            8'd15: req_cs_present = 1'b0;
            8'd16: req_ss_present = 1'b0;
            8'd17: req_eip = prm;
            8'd18: req_esp = prm;
            8'd19: begin req_protected = 1'b0; req_eip = 32'h10000; end
            8'd20: begin req_protected = 1'b0; req_cs_sel = 16'h0; req_cs_is_code = 1'b0;
                         req_ss_present = 1'b0; req_ss_dpl = 2'd0; end
            8'd21: begin req_protected = 1'b0; req_esp = 32'hFFF8; end
            8'd22: begin req_protected = 1'b0; req_lock = 1'b1; end
            8'd23: begin req_lock = 1'b1; req_cs_sel = 16'h0; end
            8'd24: begin req_cs_present = 1'b0; req_eip = 32'h20000; end
            8'd25: begin req_eip = 32'h20000; req_ss_present = 1'b0; end
            8'd26: begin req_cs_is_code = 1'b0; req_cs_present = 1'b0; end
            8'd27: begin req_ss_present = 1'b0; req_esp = 32'hFFFC; end
            8'd28: begin req_ss_sel = 16'h0022; req_ss_writable = 1'b0; end
            8'd29: begin req_cs_sel = 16'h0000; req_ss_present = 1'b0; req_esp = 32'hFFFC; end
            default: ;
        endcase
    endtask

    // Drive one request and return once the verdict is visible (negedge).
    task automatic issue();
        @(negedge clk); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        chk("R11 evaluate cycle not valid", 32'(rsp_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acknowledge();
        rsp_ack = 1'b1;
        @(posedge clk);
        @(negedge clk); rsp_ack = 1'b0;
    endtask

    initial begin
        set_base();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11 reset state: idle and no verdict.
        chk("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R11 reset req_ready", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            set_base();
            apply(VECS[i].op, VECS[i].prm);
            issue();
            chk($sformatf("R%0d vec%0d valid", VECS[i].rq, i), 32'(rsp_valid), 32'd1);
            chk($sformatf("R%0d vec%0d class", VECS[i].rq, i), 32'(rsp_fault), 32'(VECS[i].fault));
            chk($sformatf("R%0d vec%0d error", VECS[i].rq, i), 32'(rsp_err), 32'(VECS[i].err));
            chk($sformatf("R%0d vec%0d ok", VECS[i].rq, i), 32'(rsp_ok), 32'(VECS[i].fault == 3'd0));
            acknowledge();
        end

        // R11 hold: verdict persists unacknowledged; new request inputs change meanwhile.
        set_base(); req_cs_present = 1'b0;
        issue();
        set_base(); req_lock = 1'b1;
        req_valid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R11 hold valid", 32'(rsp_valid), 32'd1);
            chk("R11 hold class", 32'(rsp_fault), 32'd3);
            chk("R11 hold error", 32'(rsp_err), 32'h001B);
            chk("R11 busy not ready", 32'(req_ready), 32'd0);
        end
        req_valid = 1'b0;
        acknowledge();
        chk("R11 idle after ack", 32'(req_ready), 32'd1);
        chk("R11 valid drops after ack", 32'(rsp_valid), 32'd0);

        // R11 reset while a verdict is pending clears it.
        set_base(); req_esp = 32'hFFF8;
        issue();
        chk("R9 pending stack verdict", 32'(rsp_fault), 32'd2);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset drops verdict", 32'(rsp_valid), 32'd0);
        chk("R11 reset restores ready", 32'(req_ready), 32'd1);

        // R1 lock wins over every other broken rule at once.
        set_base(); req_lock = 1'b1; req_cs_sel = 16'h0103; req_ss_present = 1'b0;
        req_eip = 32'h30000; req_esp = 32'hFFFF;
        issue();
        chk("R1 lock over all", 32'(rsp_fault), 32'd4);
        chk("R1 lock error zero", 32'(rsp_err), 32'd0);
        acknowledge();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule